// File: doc/BRIEF.md
# Dual-Command Watchdog Timer

This block is a watchdog for a small processor core. A prescaler and a main counter run on enable pulses that stand in for a separate watchdog oscillator. When software does not service it in time, the main counter wraps and the block raises a one-cycle timeout pulse that the chip uses as a reset request. Entering the low-power halt state also restarts both counting stages. When a timeout happens while the core is halted, a second output pulses with it. That reset only restarts execution and keeps the other state.

Servicing depends on a static mode input. In single mode, one service strobe restarts the count. In dual mode, the core must issue two different service commands, called half A and half B. They may come in either order, or in the same cycle. The block keeps a record of the halves already seen. A completed pair clears the record, and so does a timeout. Seeing the same half twice is not a pair.

Top module: `wdt_dual_clear`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `timeout_o` and `halt_timeout_o` are low, and both counting stages start from zero.
- R2: With no restart, `timeout_o` is high for exactly one cycle. This happens in the cycle after the 2^(PRESCALE_W+COUNT_W)-th enabled tick. The count then continues from zero, so timeouts repeat with that same period.
- R3: Only cycles with `tick_i` high advance the count. Cycles with `tick_i` low leave it unchanged.
- R4: When `dual_mode_i` is 0 (single mode), a `clr_i` pulse restarts both stages from zero. `clr_a_i` and `clr_b_i` have no effect in this mode.
- R5: When `dual_mode_i` is 1 (dual mode), the count restarts only once both `clr_a_i` and `clr_b_i` have been seen since the last restart, in either order or in the same cycle. `clr_i` has no effect in this mode.
- R6: In dual mode, repeating one half any number of times does not restart the count.
- R7: The record of halves seen is cleared when a pair completes, when a timeout fires, and while single mode is selected.
- R8: A `halt_enter_i` pulse restarts both stages from zero in either mode.
- R9: `halt_timeout_o` pulses together with `timeout_o` when the timeout occurs while halted. Halted state begins with `halt_enter_i`. It ends with `wake_i` or with a timeout. If `halt_enter_i` and `wake_i` are high in the same cycle, `halt_enter_i` wins.
- R10: A restart (valid service or halt entry) in the same cycle as the final tick suppresses the timeout. The count restarts from zero instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Watchdog clock enable, one per watchdog oscillator period |
| dual_mode_i | input | 1 | Static servicing mode: 0 single, 1 dual |
| clr_i | input | 1 | Single-mode service strobe |
| clr_a_i | input | 1 | Dual-mode service, half A |
| clr_b_i | input | 1 | Dual-mode service, half B |
| halt_enter_i | input | 1 | Strobe on entry into the halt state |
| wake_i | input | 1 | Strobe on leaving the halt state |
| timeout_o | output | 1 | One-cycle timeout pulse |
| halt_timeout_o | output | 1 | One-cycle pulse for a timeout taken while halted |

## Verification
The bench builds the block with PRESCALE_W = 2 and COUNT_W = 3, which gives a timeout period of 32 enabled ticks instead of 65536. With this short period, the bench can reach repeated wraps and gated-tick stretches in a few hundred cycles. The same setting makes it cheap to line up a service exactly on the final tick and to let a half-recorded pair run out into a timeout. Every cycle is compared against a reference model written from the requirements, under both servicing modes and across halt and wake sequences.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   typedef enum logic {
      CLR_SINGLE = 1'b0,
      CLR_DUAL   = 1'b1
   } clr_mode_e;

   typedef struct packed {
      logic single;
      logic half_a;
      logic half_b;
   } clr_cmd_t;

endpackage

// File: rtl/wdt_stage.sv
module wdt_stage #(
   parameter int W = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic restart_i,
   input  logic inc_i,
   output logic carry_o
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 1) begin : g_bad_width
      $error("wdt_stage: W must be at least 1");
   end

   logic [W-1:0] val_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        val_q <= '0;
      else if (restart_i) val_q <= '0;
      else if (inc_i)     val_q <= val_q + 1'b1;
   end

   assign carry_o = inc_i && (val_q == TOP);

   p_restart_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart_i |=> (val_q == '0));

   p_hold_without_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!inc_i && !restart_i) |=> $stable(val_q));

endmodule

// File: rtl/wdt_clear_pair.sv
module wdt_clear_pair
   import wdt_pkg::*;
(
   input  logic      clk_i,
   input  logic      rst_ni,
   input  clr_mode_e mode_i,
   input  clr_cmd_t  cmd_i,
   input  logic      abort_i,
   output logic      svc_o
);
   logic seen_a_q, seen_b_q;
   logic pair_done;

   assign pair_done = (seen_a_q || cmd_i.half_a) && (seen_b_q || cmd_i.half_b)
                      && (cmd_i.half_a || cmd_i.half_b);

   always_comb begin
      unique case (mode_i)
         CLR_DUAL: svc_o = pair_done;
         default:  svc_o = cmd_i.single;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         seen_a_q <= 1'b0;
         seen_b_q <= 1'b0;
      end else if (mode_i != CLR_DUAL || svc_o || abort_i) begin
         seen_a_q <= 1'b0;
         seen_b_q <= 1'b0;
      end else begin
         seen_a_q <= seen_a_q || cmd_i.half_a;
         seen_b_q <= seen_b_q || cmd_i.half_b;
      end
   end

   p_record_cleared_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (svc_o || abort_i) |=> (!seen_a_q && !seen_b_q));

   p_lone_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == CLR_DUAL && !cmd_i.half_b && !seen_b_q) |-> !svc_o);

   p_single_ignores_halves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == CLR_SINGLE && !cmd_i.single) |-> !svc_o);

   p_dual_ignores_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == CLR_DUAL && !cmd_i.half_a && !cmd_i.half_b) |-> !svc_o);

endmodule

// File: rtl/wdt_dual_clear.sv
module wdt_dual_clear
   import wdt_pkg::*;
#(
   parameter int PRESCALE_W = 8,
   parameter int COUNT_W    = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic dual_mode_i,
   input  logic clr_i,
   input  logic clr_a_i,
   input  logic clr_b_i,
   input  logic halt_enter_i,
   input  logic wake_i,
   output logic timeout_o,
   output logic halt_timeout_o
);
   localparam int TOTAL_W = PRESCALE_W + COUNT_W;

   if (PRESCALE_W < 0) begin : g_bad_pre
      $error("wdt_dual_clear: PRESCALE_W must not be negative");
   end
   if (COUNT_W < 1) begin : g_bad_cnt
      $error("wdt_dual_clear: COUNT_W must be at least 1");
   end
   if (TOTAL_W > 30) begin : g_bad_total
      $error("wdt_dual_clear: total width too large");
   end

   clr_mode_e mode;
   clr_cmd_t  cmd;
   logic      svc, restart, pre_carry, expire, fire;
   logic      halted_q, timeout_q, halt_to_q;

   assign mode    = dual_mode_i ? CLR_DUAL : CLR_SINGLE;
   assign cmd     = '{single: clr_i, half_a: clr_a_i, half_b: clr_b_i};
   assign restart = svc || halt_enter_i;
   assign fire    = expire && !restart;

   wdt_clear_pair u_pair (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode),
      .cmd_i   (cmd),
      .abort_i (fire),
      .svc_o   (svc)
   );

   if (PRESCALE_W == 0) begin : g_no_pre
      assign pre_carry = tick_i;
   end else begin : g_pre
      wdt_stage #(.W(PRESCALE_W)) u_pre (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .restart_i (restart),
         .inc_i     (tick_i),
         .carry_o   (pre_carry)
      );
   end

   wdt_stage #(.W(COUNT_W)) u_main (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .restart_i (restart),
      .inc_i     (pre_carry),
      .carry_o   (expire)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         halted_q  <= 1'b0;
         timeout_q <= 1'b0;
         halt_to_q <= 1'b0;
      end else begin
         timeout_q <= fire;
         halt_to_q <= fire && halted_q;
         if (halt_enter_i)          halted_q <= 1'b1;
         else if (wake_i || fire)   halted_q <= 1'b0;
      end
   end

   assign timeout_o      = timeout_q;
   assign halt_timeout_o = halt_to_q;

   p_one_cycle_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o |=> !timeout_o);

   p_halt_flag_with_timeout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_timeout_o |-> timeout_o);

   p_restart_suppresses_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      restart |=> !timeout_o);

   p_quiet_after_reset_r1: assert property (@(posedge clk_i)
      !rst_ni |=> (!timeout_o && !halt_timeout_o));

endmodule

// File: tb/wdt_dual_clear_test.sv
module wdt_dual_clear_test;
   localparam int PW = 2;
   localparam int CW = 3;
   localparam int N  = 1 << (PW + CW);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, dual = 1'b0, clr = 1'b0, clr_a = 1'b0, clr_b = 1'b0;
   logic halt_en = 1'b0, wake = 1'b0;
   logic timeout, halt_to;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic  to;
      logic  hto;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   int m_cnt = 0;
   bit m_sa = 0, m_sb = 0, m_halted = 0;

   always #2 clk = ~clk;

   wdt_dual_clear #(.PRESCALE_W(PW), .COUNT_W(CW)) uut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .dual_mode_i(dual),
      .clr_i(clr), .clr_a_i(clr_a), .clr_b_i(clr_b),
      .halt_enter_i(halt_en), .wake_i(wake),
      .timeout_o(timeout), .halt_timeout_o(halt_to));

   task automatic check(input logic act, input logic exp, input string tag, input string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   // driver: drive one cycle of stimulus and push the model's expectation
   task automatic step(input logic t, input logic c, input logic a, input logic b,
                       input logic he, input logic wk, input string tag);
      bit svc, rs, ex;
      @(negedge clk);
      tick = t; clr = c; clr_a = a; clr_b = b; halt_en = he; wake = wk;
      if (dual) svc = (m_sa || a) && (m_sb || b) && (a || b);
      else      svc = c;
      rs = svc || he;
      ex = t && (m_cnt == N - 1) && !rs;
      sb_q.push_back('{to: ex, hto: ex && m_halted, tag: tag});
      if (rs)     m_cnt = 0;
      else if (t) m_cnt = (m_cnt + 1) % N;
      if (!dual || svc || ex) begin m_sa = 0; m_sb = 0; end
      else begin m_sa = m_sa || a; m_sb = m_sb || b; end
      if (he)            m_halted = 1;
      else if (wk || ex) m_halted = 0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, tag);
   endtask

   // monitor: compare after each edge
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(timeout, e.to, e.tag, "timeout_o");
         check(halt_to, e.hto, e.tag, "halt_timeout_o");
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(timeout, 1'b0, "R1", "timeout_o in reset");
      check(halt_to, 1'b0, "R1", "halt_timeout_o in reset");
      @(negedge clk);
      rst_n = 1'b1;
      // R1/R2: count from zero after reset, two full periods
      idle(2 * N + 5, "R2");
      // R3: ticks on alternate cycles only
      for (int i = 0; i < 2 * N + 6; i++) step(i[0], 0, 0, 0, 0, 0, "R3");
      // R4: single mode service keeps timeout away
      dual = 0;
      step(1, 1, 0, 0, 0, 0, "R4");
      for (int k = 0; k < 5; k++) begin
         idle(N - 3, "R4");
         step(1, 1, 0, 0, 0, 0, "R4");
      end
      // R4: halves ignored in single mode
      for (int k = 0; k < 4; k++) begin
         idle(9, "R4");
         step(1, 0, 1, 1, 0, 0, "R4");
      end
      // R10: service exactly on the final tick
      step(1, 1, 0, 0, 0, 0, "R10");
      idle(N - 1, "R10");
      step(1, 1, 0, 0, 0, 0, "R10");
      idle(N + 2, "R10");
      // R5: dual mode, A then B, B then A, same cycle
      dual = 1;
      step(1, 0, 0, 0, 1, 1, "R8");
      for (int k = 0; k < 3; k++) begin
         idle(10, "R5");
         step(1, 0, 1, 0, 0, 0, "R5");
         idle(8, "R5");
         step(1, 0, 0, 1, 0, 0, "R5");
         idle(8, "R5");
         step(1, 0, 0, 1, 0, 0, "R5");
         idle(4, "R5");
         step(1, 0, 1, 0, 0, 0, "R5");
         idle(6, "R5");
         step(1, 0, 1, 1, 0, 0, "R5");
      end
      // R5: single strobe ignored in dual mode
      for (int k = 0; k < 5; k++) begin
         idle(8, "R5");
         step(1, 1, 0, 0, 0, 0, "R5");
      end
      // R6: repeated half A never completes
      step(1, 0, 1, 1, 0, 0, "R6");
      for (int k = 0; k < 6; k++) begin
         idle(7, "R6");
         step(1, 0, 1, 0, 0, 0, "R6");
      end
      // R7: half recorded, then timeout clears it, then lone B
      step(1, 0, 1, 1, 0, 0, "R7");
      idle(3, "R7");
      step(1, 0, 1, 0, 0, 0, "R7");
      idle(N, "R7");
      step(1, 0, 0, 1, 0, 0, "R7");
      idle(N + 2, "R7");
      // R7: record cleared by single mode
      step(1, 0, 1, 1, 0, 0, "R7");
      step(1, 0, 1, 0, 0, 0, "R7");
      dual = 0;
      idle(2, "R7");
      dual = 1;
      step(1, 0, 0, 1, 0, 0, "R7");
      idle(N + 2, "R7");
      // R8: halt entry restarts in dual mode, then R9 halted timeout
      idle(N - 4, "R8");
      step(1, 0, 0, 0, 1, 0, "R8");
      idle(N + 3, "R9");
      idle(N + 1, "R9");
      // R9: wake clears halted state
      step(1, 0, 0, 0, 1, 0, "R9");
      idle(5, "R9");
      step(1, 0, 0, 0, 0, 1, "R9");
      idle(N + 2, "R9");
      // R10: halt entry on the final tick
      dual = 0;
      step(1, 1, 0, 0, 0, 0, "R10");
      idle(N - 1, "R10");
      step(1, 0, 0, 0, 1, 0, "R10");
      idle(N + 2, "R10");
      step(0, 0, 0, 0, 0, 0, "R3");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule